// File: doc/BRIEF.md
# Wired-AND Link Handshake Port

This block gives one unit of a two-unit link a handshake register built on two shared control lines, a "ready" line and a "flag" line. Each unit drives its lines open-drain: it pulls a line low for a 0 and lets it go for a 1. A line therefore reads high only when both units let it go. Software writes a local ready bit and a local flag bit. It reads back the combined ready level. It also reads a latched sample, which is taken when the serial controller signals the end of a data exchange. Both line levels pass through a two-flop synchroniser before the block uses them.

When no peer is attached, or the peer is powered down, the block ignores the cable levels. It then acts as though an invisible peer held exactly the local settings, so the combined values equal the local bits. The register has its own interrupt, independent of the serial-transfer interrupt. A falling edge of the combined ready level raises it while the inhibit bit is clear. It stays pending until software writes the inhibit bit to 1.

Register write layout (`reg_wdata`): bit 0 is the local ready bit, bit 1 is the local flag bit, and bit 2 is the inhibit/acknowledge bit. Read layout (`reg_rdata`): bit 0 ready, bit 1 flag, bit 2 inhibit, bit 3 combined ready, bit 4 sample, bit 5 pending. Bits 7:6 read 0.

Top module: `link_hs_port`

## Requirements
- R1: After reset, `reg_rdata` is 8'h0B: ready=1, flag=1, inhibit=0, combined ready=1, sample=0, pending=0. Both pull outputs are 0 and `irq` is 0.
- R2: `rdy_pull_low` is the inverse of the stored ready bit, and `flg_pull_low` is the inverse of the stored flag bit. Both take their new value on the clock edge that accepts a write.
- R3: With `peer_present`=1, the combined ready bit (read bit 3) equals the synchronised `rdy_line` level. With an attached peer that level is the AND of both units' ready bits.
- R4: With `peer_present`=0, the combined ready bit equals the local ready bit whatever `rdy_line` carries. It follows a write on the same edge.
- R5: On a cycle with `xfer_done`=1, the sample bit (read bit 4) is loaded with combined flag AND combined ready. On every other cycle it holds its value.
- R6: With `peer_present`=0, the combined flag used by R5 is the local flag bit, and `flg_line` is ignored.
- R7: A falling edge of the combined ready bit while inhibit is 0 sets pending (read bit 5 and `irq`) one clock later.
- R8: Pending stays set until a write with `reg_wdata[2]`=1. `xfer_done` does not clear it, and neither does a write with bit 2 = 0.
- R9: While inhibit is 1, a falling edge of the combined ready bit does not set pending.
- R10: A change on `rdy_line` reaches the combined ready bit after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data: [0] ready, [1] flag, [2] inhibit/ack |
| reg_rdata | output | 8 | Read data: [0] ready, [1] flag, [2] inhibit, [3] combined ready, [4] sample, [5] pending |
| rdy_pull_low | output | 1 | 1 = pull the ready line low |
| flg_pull_low | output | 1 | 1 = pull the flag line low |
| rdy_line | input | 1 | Sensed ready line level |
| flg_line | input | 1 | Sensed flag line level |
| peer_present | input | 1 | 1 = a powered peer is attached |
| xfer_done | input | 1 | One-cycle end-of-exchange strobe |
| irq | output | 1 | Pending handshake interrupt |

## Verification
With a peer attached, the bench drives the ready and flag bits through all four local/peer combinations. This separates a true AND from an OR or a local-only read. With the peer detached, the cable lines are forced low, which shows that the invisible peer copies the local settings instead of reading the lines. For the sample, the bench changes the flag levels between strobes, which tells a latch apart from a transparent path. It also clears the ready level with the flag set, which shows that the sample includes the ready term. A one-edge and a two-edge probe of `rdy_line` pin the synchroniser depth. Interrupt tests pair a falling ready edge with the inhibit clear and with it set. They then apply a transfer strobe and a zero-inhibit write to show that only the acknowledge clears pending.

// File: rtl/link_hs_port.sv
module link_hs_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          rdy_pull_low,
  output logic          flg_pull_low,
  input  logic          rdy_line,
  input  logic          flg_line,
  input  logic          peer_present,
  input  logic          xfer_done,
  output logic          irq
);

  logic       rdy_bit, flg_bit, inh, pend, smp, rdy_q;
  logic [1:0] rdy_s, flg_s;
  logic       rdy_eff, flg_eff, fall, ack;
  logic [1:0] age;

  assign rdy_eff = peer_present ? rdy_s[1] : rdy_bit;
  assign flg_eff = peer_present ? flg_s[1] : flg_bit;
  assign fall    = rdy_q & ~rdy_eff;
  assign ack     = reg_we & reg_wdata[2];

  assign rdy_pull_low = ~rdy_bit;
  assign flg_pull_low = ~flg_bit;
  assign irq          = pend;
  assign reg_rdata    = {{(DW-6){1'b0}}, pend, smp, rdy_eff, inh, flg_bit, rdy_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_s <= 2'b11;
      flg_s <= 2'b11;
    end else begin
      rdy_s <= {rdy_s[0], rdy_line};
      flg_s <= {flg_s[0], flg_line};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_bit <= 1'b1;
      flg_bit <= 1'b1;
      inh     <= 1'b0;
    end else if (reg_we) begin
      rdy_bit <= reg_wdata[0];
      flg_bit <= reg_wdata[1];
      inh     <= reg_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b1;
      pend  <= 1'b0;
      smp   <= 1'b0;
      age   <= '0;
    end else begin
      rdy_q <= rdy_eff;
      if (ack)              pend <= 1'b0;
      else if (fall && !inh) pend <= 1'b1;
      if (xfer_done) smp <= flg_eff & rdy_eff;
      if (age != 2'd3) age <= age + 2'd1;
    end
  end

  // R2
  pull_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (rdy_pull_low == !$past(reg_wdata[0])) && (flg_pull_low == !$past(reg_wdata[1])));

  // R5
  smp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_done |=> $stable(reg_rdata[4]));

  // R7
  fall_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(reg_rdata[3]) && !reg_rdata[2] && !(reg_we && reg_wdata[2])) |=> irq);

  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_we && reg_wdata[2])) |=> irq);

  // R9
  inh_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && reg_rdata[2]) |=> !irq);

  // R10
  sync_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_present && age >= 2'd2) |-> (reg_rdata[3] == $past(rdy_line, 2)));

endmodule

// File: tb/link_hs_port_tb.sv
module link_hs_port_tb_top;
  localparam int PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       reg_we = 0, peer_present = 0, xfer_done = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       rdy_pull_low, flg_pull_low, irq;
  logic       peer_rdy = 1, peer_flg = 1;
  logic       rdy_line, flg_line;
  int         checks = 0, failures = 0;

  assign rdy_line = peer_present ? (~rdy_pull_low & peer_rdy) : 1'b0;
  assign flg_line = peer_present ? (~flg_pull_low & peer_flg) : 1'b0;

  always #(PERIOD/2) clk = ~clk;

  link_hs_port dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .rdy_pull_low(rdy_pull_low), .flg_pull_low(flg_pull_low),
    .rdy_line(rdy_line), .flg_line(flg_line), .peer_present(peer_present),
    .xfer_done(xfer_done), .irq(irq));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] v);
    reg_we = 1; reg_wdata = {5'b0, v};
    @(posedge clk); @(negedge clk);
    reg_we = 0; reg_wdata = 0;
  endtask

  task automatic pulse;
    xfer_done = 1;
    @(posedge clk); @(negedge clk);
    xfer_done = 0;
  endtask

  task automatic t_reset;
    chk("R1 rdata", reg_rdata, 8'h0B);
    chk("R1 pulls", {6'b0, rdy_pull_low, flg_pull_low}, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_open_drain;
    wr(3'b110);
    chk("R2 ready low", {7'b0, rdy_pull_low}, 8'h01);
    chk("R2 flag rel", {7'b0, flg_pull_low}, 8'h00);
    wr(3'b101);
    chk("R2 ready rel", {7'b0, rdy_pull_low}, 8'h00);
    chk("R2 flag low", {7'b0, flg_pull_low}, 8'h01);
  endtask

  task automatic t_peer_and;
    peer_present = 1;
    for (int k = 0; k < 4; k++) begin
      peer_rdy = k[0];
      wr({1'b1, 1'b1, k[1]});
      tick(4);
      chk("R3 and", {7'b0, reg_rdata[3]}, {7'b0, k[0] & k[1]});
    end
    peer_rdy = 0;
    @(posedge clk); #1;
    chk("R10 one edge", {7'b0, reg_rdata[3]}, 8'h01);
    @(posedge clk); #1;
    chk("R10 two edges", {7'b0, reg_rdata[3]}, 8'h00);
    peer_rdy = 1;
    tick(4);
  endtask

  task automatic t_absent;
    peer_present = 0;
    wr(3'b111);
    chk("R4 local one", {7'b0, reg_rdata[3]}, 8'h01);
    pulse;
    chk("R6 smp local", {7'b0, reg_rdata[4]}, 8'h01);
    wr(3'b110);
    chk("R4 local zero", {7'b0, reg_rdata[3]}, 8'h00);
    pulse;
    chk("R6 smp ready term", {7'b0, reg_rdata[4]}, 8'h00);
  endtask

  task automatic t_sample;
    peer_present = 1; peer_rdy = 1; peer_flg = 1;
    wr(3'b111);
    tick(4);
    pulse;
    chk("R5 both set", {7'b0, reg_rdata[4]}, 8'h01);
    peer_flg = 0;
    tick(4);
    chk("R5 hold", {7'b0, reg_rdata[4]}, 8'h01);
    pulse;
    chk("R5 flag and", {7'b0, reg_rdata[4]}, 8'h00);
    peer_flg = 1; peer_rdy = 0;
    tick(4);
    pulse;
    chk("R5 ready and", {7'b0, reg_rdata[4]}, 8'h00);
    peer_rdy = 1;
    tick(4);
  endtask

  task automatic t_irq;
    peer_present = 0;
    wr(3'b011);
    tick(1);
    chk("R7 quiet", {7'b0, irq}, 8'h00);
    wr(3'b010);
    tick(1);
    chk("R7 raise", {7'b0, irq}, 8'h01);
    chk("R7 pend bit", {7'b0, reg_rdata[5]}, 8'h01);
    pulse;
    chk("R8 xfer keeps", {7'b0, irq}, 8'h01);
    wr(3'b010);
    tick(1);
    chk("R8 no-ack keeps", {7'b0, irq}, 8'h01);
    wr(3'b111);
    chk("R8 ack clears", {7'b0, irq}, 8'h00);
    wr(3'b110);
    tick(2);
    chk("R9 inhibited", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    #(PERIOD * 200000);
    failures++;
    $display("FAIL watchdog got=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tick(3);
    t_reset;
    rst_n = 1;
    tick(1);
    t_reset;
    t_open_drain;
    t_peer_and;
    t_absent;
    t_sample;
    t_irq;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule